// File: doc/BRIEF.md
# Serial LCD Command Interpreter

This block is the byte-level back end of a two-wire bus slave in an LCD controller. A bit-level receiver in front of it reports START and STOP conditions and complete bytes through single-cycle strobes. The block matches the first byte after START against its 7-bit device address, and acknowledges it only for a write. It then reads command bytes that are chained by a continuation flag in bit 7. The first command byte with that flag cleared is the last command, and every byte after it is display data.

The configuration sits in plain registers: drive mode, bias, display enable, blink rate, blink style, a column pointer and a 3-bit bank-select counter. A data byte is passed to the display RAM write port only when the bank-select counter equals the 3-bit hardware address strapped on pins. The column pointer moves on after every data byte, and when it wraps past the last column the bank-select counter steps up. This lets several devices on one bus share a single data stream. While a stored byte waits for the RAM to accept it, the block asks the receiver to hold the bus clock low.

Top module: `lcdc_cmd_top`

## Requirements
- R1: After reset, every configuration output, the pointer, the bank-select counter, `ack`, `stretch` and `wr_req` are 0.
- R2: The first byte after START is accepted only if it equals {6'b011100, addr_strap, 1'b0}. An accepted byte raises `ack` for one cycle, in the cycle after its strobe. Any other value, including the matching address with bit 0 (read) set, gets no `ack`, and all bytes up to the next START are then ignored.
- R3: In a command byte, bit 7 set means the next byte is also a command. Bit 7 clear means every later byte of the transfer is display data. Every command and data byte is acknowledged.
- R4: The mode command, bits 6:4 = 100, loads `disp_en` from bit 3, `bias_half` from bit 2 (0 gives one-third bias, 1 gives one-half bias) and `mux_mode` from bits 1:0.
- R5: The blink command, bits 6:3 = 1110, loads `blink_alt` from bit 2 (0 for normal blinking, 1 for alternate-bank blinking) and `blink_freq` from bits 1:0 (00 is off, 01 to 11 are rates 1 to 3).
- R6: The device-select command, bits 6:3 = 1100, loads `sub_addr` from bits 2:0.
- R7: The pointer command, bits 6:5 = 01, loads `data_ptr` from bits 4:0. A value of NCOL or more loads 0.
- R8: A data byte raises `wr_req`, with `wr_addr` set to the current pointer and `wr_data` set to the byte, only if `sub_addr` equals `hw_sub`. Otherwise no write is made.
- R9: Every data byte advances `data_ptr` by one, whether or not it is stored. After column NCOL-1 the pointer goes to 0 and `sub_addr` increments, modulo 8.
- R10: `stretch` is high from the cycle after a stored byte until the cycle after `wr_done` is seen with `wr_req`. While a request waits, `wr_addr` and `wr_data` hold steady. Every stored byte reaches the port in order.
- R11: START returns the block to address matching. After STOP, bytes get no `ack` and change nothing until the next START. The configuration persists across transfers.
- R12: Command codes 00xxxxx, 1101xxx and 1111xxx in bits 6:0 change no register, but their bit 7 still selects command or data for the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_start | input | 1 | START condition strobe |
| bus_stop | input | 1 | STOP condition strobe |
| byte_valid | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte |
| addr_strap | input | 1 | Device address strap bit |
| hw_sub | input | 3 | Hardware bank address pins |
| wr_done | input | 1 | RAM accepts the pending write |
| ack | output | 1 | Acknowledge for the last byte |
| stretch | output | 1 | Hold the bus clock low |
| wr_req | output | 1 | Display RAM write request |
| wr_addr | output | PTR_W (5) | RAM column to write |
| wr_data | output | 8 | Byte to write |
| mux_mode | output | 2 | Drive mode |
| bias_half | output | 1 | Bias select |
| disp_en | output | 1 | Display enable |
| blink_freq | output | 2 | Blink rate |
| blink_alt | output | 1 | Blink style |
| sub_addr | output | 3 | Bank-select counter |
| data_ptr | output | PTR_W (5) | Column pointer |

## Verification
The assertions assume that the receiver never delivers a byte while `stretch` is high, and never raises START, STOP and a byte strobe in the same cycle. The hardware address pins are taken to be constant. The stimulus tasks wait for `stretch` to drop before they drive a byte, pulse each strobe alone for one cycle, and tie `hw_sub` and `addr_strap` for the whole run. The RAM model in the bench answers with a programmable delay, so the stall path is exercised without breaking those assumptions.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int CMD_PTR_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_DATA
    } lcdc_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PTR,
        OP_MODE,
        OP_DEVSEL,
        OP_BLINK
    } lcdc_op_e;

    typedef struct packed {
        lcdc_op_e               op;
        logic                   more;
        logic [CMD_PTR_W-1:0]   ptr_val;
        logic [2:0]             sub_val;
        logic                   en_val;
        logic                   bias_val;
        logic [1:0]             mux_val;
        logic                   alt_val;
        logic [1:0]             freq_val;
    } lcdc_cmd_t;

endpackage

// File: rtl/lcdc_addr_match.sv
module lcdc_addr_match #(
    parameter logic [5:0] ADDR_HI = 6'b011100
) (
    input  logic [7:0] byte_in,
    input  logic       strap,
    output logic       hit
);
    // Only a write to this device's address is accepted.
    always_comb begin
        hit = (byte_in[7:2] == ADDR_HI) && (byte_in[1] == strap) && !byte_in[0];
    end
endmodule

// File: rtl/lcdc_cmd_decode.sv
module lcdc_cmd_decode
    import lcdc_pkg::*;
(
    input  logic [7:0] byte_in,
    output lcdc_cmd_t  cmd
);
    always_comb begin
        cmd.op = OP_NONE;
        if (byte_in[6:5] == 2'b01) begin
            cmd.op = OP_PTR;
        end else if (byte_in[6:4] == 3'b100) begin
            cmd.op = OP_MODE;
        end else if (byte_in[6:3] == 4'b1100) begin
            cmd.op = OP_DEVSEL;
        end else if (byte_in[6:3] == 4'b1110) begin
            cmd.op = OP_BLINK;
        end
        cmd.more     = byte_in[7];
        cmd.ptr_val  = byte_in[CMD_PTR_W-1:0];
        cmd.sub_val  = byte_in[2:0];
        cmd.en_val   = byte_in[3];
        cmd.bias_val = byte_in[2];
        cmd.mux_val  = byte_in[1:0];
        cmd.alt_val  = byte_in[2];
        cmd.freq_val = byte_in[1:0];
    end
endmodule

// File: rtl/lcdc_store_buf.sv
module lcdc_store_buf #(
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] ld_addr,
    input  logic [7:0]       ld_data,
    input  logic             wr_done,
    output logic             wr_req,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data
);
    typedef struct packed {
        logic             pend;
        logic [PTR_W-1:0] addr;
        logic [7:0]       data;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (buf_q.pend && wr_done) begin
            buf_d.pend = 1'b0;
        end
        if (load) begin
            buf_d.pend = 1'b1;
            buf_d.addr = ld_addr;
            buf_d.data = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign wr_req  = buf_q.pend;
    assign wr_addr = buf_q.addr;
    assign wr_data = buf_q.data;
endmodule

// File: rtl/lcdc_cmd_top.sv
module lcdc_cmd_top
    import lcdc_pkg::*;
#(
    parameter int         NCOL    = 24,
    parameter logic [5:0] ADDR_HI = 6'b011100,
    parameter int         PTR_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_start,
    input  logic             bus_stop,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             addr_strap,
    input  logic [2:0]       hw_sub,
    input  logic             wr_done,
    output logic             ack,
    output logic             stretch,
    output logic             wr_req,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [1:0]       mux_mode,
    output logic             bias_half,
    output logic             disp_en,
    output logic [1:0]       blink_freq,
    output logic             blink_alt,
    output logic [2:0]       sub_addr,
    output logic [PTR_W-1:0] data_ptr
);
    localparam logic [PTR_W-1:0]     LAST_COL = PTR_W'(NCOL - 1);
    localparam logic [CMD_PTR_W:0]   NCOL_V   = (CMD_PTR_W + 1)'(NCOL);

    typedef struct packed {
        lcdc_state_e      st;
        logic [PTR_W-1:0] ptr;
        logic [2:0]       sub;
        logic [1:0]       mux;
        logic             bias;
        logic             en;
        logic [1:0]       freq;
        logic             alt;
        logic             ack;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    logic      addr_hit;
    lcdc_cmd_t cmd;
    logic      store;

    lcdc_addr_match #(.ADDR_HI(ADDR_HI)) addr_i (
        .byte_in (byte_data),
        .strap   (addr_strap),
        .hit     (addr_hit)
    );

    lcdc_cmd_decode dec_i (
        .byte_in (byte_data),
        .cmd     (cmd)
    );

    lcdc_store_buf #(.PTR_W(PTR_W)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (store),
        .ld_addr (ctl_q.ptr),
        .ld_data (byte_data),
        .wr_done (wr_done),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ack = 1'b0;
        store     = 1'b0;
        if (bus_stop) begin
            ctl_d.st = ST_IDLE;
        end else if (bus_start) begin
            ctl_d.st = ST_ADDR;
        end else if (byte_valid) begin
            unique case (ctl_q.st)
                ST_ADDR: begin
                    if (addr_hit) begin
                        ctl_d.ack = 1'b1;
                        ctl_d.st  = ST_CMD;
                    end else begin
                        ctl_d.st  = ST_IDLE;
                    end
                end
                ST_CMD: begin
                    ctl_d.ack = 1'b1;
                    unique case (cmd.op)
                        OP_PTR: begin
                            if ({1'b0, cmd.ptr_val} < NCOL_V) begin
                                ctl_d.ptr = cmd.ptr_val[PTR_W-1:0];
                            end else begin
                                ctl_d.ptr = '0;
                            end
                        end
                        OP_MODE: begin
                            ctl_d.en   = cmd.en_val;
                            ctl_d.bias = cmd.bias_val;
                            ctl_d.mux  = cmd.mux_val;
                        end
                        OP_DEVSEL: ctl_d.sub = cmd.sub_val;
                        OP_BLINK: begin
                            ctl_d.alt  = cmd.alt_val;
                            ctl_d.freq = cmd.freq_val;
                        end
                        default: ;
                    endcase
                    ctl_d.st = cmd.more ? ST_CMD : ST_DATA;
                end
                ST_DATA: begin
                    ctl_d.ack = 1'b1;
                    store     = (ctl_q.sub == hw_sub);
                    if (ctl_q.ptr == LAST_COL) begin
                        ctl_d.ptr = '0;
                        ctl_d.sub = ctl_q.sub + 3'd1;
                    end else begin
                        ctl_d.ptr = ctl_q.ptr + PTR_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ack        = ctl_q.ack;
    assign stretch    = wr_req;
    assign mux_mode   = ctl_q.mux;
    assign bias_half  = ctl_q.bias;
    assign disp_en    = ctl_q.en;
    assign blink_freq = ctl_q.freq;
    assign blink_alt  = ctl_q.alt;
    assign sub_addr   = ctl_q.sub;
    assign data_ptr   = ctl_q.ptr;
endmodule

// File: rtl/lcdc_cmd_checker.sv
module lcdc_cmd_checker #(
    parameter int NCOL  = 24,
    parameter int PTR_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_stop,
    input logic             byte_valid,
    input logic [2:0]       hw_sub,
    input logic             wr_done,
    input logic             ack,
    input logic             stretch,
    input logic             wr_req,
    input logic [PTR_W-1:0] wr_addr,
    input logic [7:0]       wr_data,
    input logic [2:0]       sub_addr,
    input logic [PTR_W-1:0] data_ptr
);
    p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(byte_valid));

    p_wr_only_on_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(sub_addr == hw_sub));

    p_ptr_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(data_ptr) < NCOL);

    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_done) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    p_no_byte_in_stretch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |-> !byte_valid);

    p_quiet_after_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !ack);
endmodule

bind lcdc_cmd_top lcdc_cmd_checker #(.NCOL(NCOL), .PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_stop   (bus_stop),
    .byte_valid (byte_valid),
    .hw_sub     (hw_sub),
    .wr_done    (wr_done),
    .ack        (ack),
    .stretch    (stretch),
    .wr_req     (wr_req),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sub_addr   (sub_addr),
    .data_ptr   (data_ptr)
);

// File: tb/lcdc_cmd_top_tb_top.sv
module lcdc_cmd_top_tb_top;
    localparam int PTR_W = 5;
    localparam logic [2:0] HW = 3'd5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_start = 1'b0, bus_stop = 1'b0, byte_valid = 1'b0;
    logic [7:0]       byte_data = '0;
    logic             addr_strap = 1'b1;
    logic [2:0]       hw_sub = HW;
    logic             wr_done = 1'b0;
    logic             ack, stretch, wr_req, bias_half, disp_en, blink_alt;
    logic [PTR_W-1:0] wr_addr, data_ptr;
    logic [7:0]       wr_data;
    logic [1:0]       mux_mode, blink_freq;
    logic [2:0]       sub_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int stall = 0;
    int wait_cnt = 0;
    logic [12:0] exp_q[$];

    always #2.5 clk = ~clk;

    lcdc_cmd_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .byte_valid(byte_valid), .byte_data(byte_data), .addr_strap(addr_strap),
        .hw_sub(hw_sub), .wr_done(wr_done), .ack(ack), .stretch(stretch),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .mux_mode(mux_mode),
        .bias_half(bias_half), .disp_en(disp_en), .blink_freq(blink_freq),
        .blink_alt(blink_alt), .sub_addr(sub_addr), .data_ptr(data_ptr)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: RAM model with a programmable delay, pops the scoreboard.
    always @(negedge clk) begin
        wr_done <= 1'b0;
        if (rst_n && wr_req && !wr_done) begin
            if (wait_cnt >= stall) begin
                wait_cnt = 0;
                wr_done <= 1'b1;
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R8: actual write %0d:%0h expected none", wr_addr, wr_data);
                end else begin
                    logic [12:0] e;
                    e = exp_q.pop_front();
                    if (e != {wr_addr, wr_data}) begin
                        n_bad++;
                        $display("FAIL R10: actual %0h expected %0h", {wr_addr, wr_data}, e);
                    end
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    task automatic strobe_start();
        @(negedge clk); bus_start = 1'b1;
        @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic strobe_stop();
        @(negedge clk); bus_stop = 1'b1;
        @(negedge clk); bus_stop = 1'b0;
    endtask

    // Drives one byte; on return ack and registers reflect it.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        while (stretch) @(negedge clk);
        byte_valid = 1'b1; byte_data = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    int exp_ptr = 0;
    int exp_sub = 0;

    task automatic send_data(input logic [7:0] b);
        if (exp_sub == int'(HW)) exp_q.push_back({5'(exp_ptr), b});
        send(b);
        check("R3 data ack", int'(ack), 1);
        if (exp_sub == int'(HW)) check("R10 stretch", int'(stretch), 1);
        if (exp_ptr == 23) begin exp_ptr = 0; exp_sub = (exp_sub + 1) % 8; end
        else exp_ptr++;
        check("R9 ptr", int'(data_ptr), exp_ptr);
        check("R9 sub", int'(sub_addr), exp_sub);
    endtask

    task automatic drain();
        repeat (12) @(negedge clk);
        check("R10 all writes seen", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ack", int'(ack), 0);
        check("R1 stretch", int'(stretch), 0);
        check("R1 wr_req", int'(wr_req), 0);
        check("R1 cfg", int'({mux_mode, bias_half, disp_en, blink_freq, blink_alt}), 0);
        check("R1 sub/ptr", int'({sub_addr, data_ptr}), 0);
        rst_n = 1'b1;

        // R11: no START, byte ignored
        send(8'h72); check("R11 idle byte", int'(ack), 0);
        // R2: wrong strap bit
        strobe_start(); send(8'h70); check("R2 wrong addr", int'(ack), 0);
        send(8'hCF); check("R2 ignored ack", int'(ack), 0);
        check("R2 ignored cfg", int'(mux_mode), 0);
        // R2: read bit set
        strobe_start(); send(8'h73); check("R2 read addr", int'(ack), 0);

        // R2 match, R4..R7, R12
        strobe_start(); send(8'h72); check("R2 ack", int'(ack), 1);
        send(8'hCF); check("R4 ack", int'(ack), 1);
        check("R4 mode", int'({disp_en, bias_half, mux_mode}), 4'b1111);
        send(8'hF6); check("R5 blink", int'({blink_alt, blink_freq}), 3'b110);
        send(8'hE9); check("R12 reserved ack", int'(ack), 1);
        check("R12 no change", int'({disp_en, bias_half, mux_mode, blink_alt, blink_freq}), 7'b1111110);
        send(8'hE5); check("R6 devsel", int'(sub_addr), 5);
        send(8'h36); check("R7 ptr", int'(data_ptr), 22);
        exp_ptr = 22; exp_sub = 5; stall = 2;
        send_data(8'hAA);
        send_data(8'hBB);   // wraps to sub 6
        send_data(8'hCC);   // not stored (R8)
        drain();

        // R11: after STOP bytes ignored, config kept
        strobe_stop(); send(8'h21); check("R11 stop ack", int'(ack), 0);
        check("R11 keep ptr", int'(data_ptr), 1);
        check("R11 keep cfg", int'({disp_en, mux_mode}), 3'b111);

        // R7 out of range, R10 with stalls
        strobe_start(); send(8'h72);
        send(8'hBE); check("R7 out of range", int'(data_ptr), 0);
        send(8'h65); check("R6 devsel last", int'(sub_addr), 5);
        exp_ptr = 0; exp_sub = 5; stall = 3;
        send_data(8'h11);
        stall = 0;
        send_data(8'h22);
        stall = 1;
        send_data(8'h33);
        drain();

        // R3: mode set with bit 7 clear, next byte is data
        strobe_start(); send(8'h72);
        send(8'h41); check("R4 mode2", int'({disp_en, bias_half, mux_mode}), 4'b0001);
        send_data(8'h5A);
        drain();

        // R12 reserved with continuation clear still switches to data
        strobe_start(); send(8'h72);
        send(8'h80 | 8'h05); check("R12 reserved 00", int'(data_ptr), 4);
        send(8'h69);   // 1101 code, bit 7 clear
        send_data(8'h77);
        drain();

        // R9 sub wrap 7 -> 0
        strobe_start(); send(8'h72);
        send(8'hE7); send(8'h37);
        exp_ptr = 23; exp_sub = 7;
        send_data(8'h44);
        check("R9 wrap sub", int'(sub_addr), 0);
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule